// File: doc/BRIEF.md
# Dual-mode FSK receive data interface

This block takes the bit level produced by an FSK demodulator, together with a sampling enable that ticks sixteen times per bit, and recovers asynchronous character frames from it. A frame is a low start bit, eight data bits with the least significant bit first, and one high stop bit. The recovered data is offered on a three-wire interface: a data line, a clock line and a data-ready line.

A mode pin chooses how the three wires behave. With the mode pin low, the raw demodulated level is sent straight to the data line. The block drives the clock line with a short pulse at the centre of every bit of a confirmed frame. With the mode pin high, each good byte is held in a one-byte buffer. The data-ready line pulses low for one bit time, and an external controller reads the byte by driving the clock line itself, one bit per rising edge. When the mode pin is high and both other control pins are low, the block is powered down: it halts and holds its outputs inactive.

The framer is a four-state machine. The states are IDLE, START, DATA and STOP. It moves IDLE→START on a high-to-low step of the input. It moves START→IDLE if the input is high again at mid-bit, which rejects a glitch, and START→DATA at the end of the start bit. It moves DATA→STOP once the eighth data bit has ended. It moves STOP→IDLE at the stop bit's mid-point, whatever level it samples. Power-down forces every state back to IDLE.

Top module: `fsk_rx_iface`

## Requirements
- R1: While mode_sel=1, ctl_a=0 and ctl_b=0, the outputs are held at data_out=0, dclk_out=0, dclk_oe=0 and dr_n=1. A frame received in this state is ignored: it produces no data-ready pulse and leaves the buffered byte unchanged.
- R2: When mode_sel=0 and the block is not powered down, data_out follows rx_bit in the same cycle, and dr_n stays 1.
- R3: When mode_sel=0, dclk_oe=1. dclk_out is high for exactly one system cycle at each of the ten sampling instants of a confirmed frame. With os_tick high every cycle, the input first seen low at edge k gives pulses after edges k+16j+8, for j=0..9.
- R4: A low level that has ended before the start bit's mid-point is rejected. It causes no dclk_out pulse and no byte.
- R5: When mode_sel=1, a frame whose stop bit samples high sets dr_n low for 16 os_tick periods. The low period starts one cycle after the stop-bit sample, and data_out then shows bit 0 of the new byte.
- R6: When mode_sel=1, each rising edge on dclk_in advances data_out to the next bit, least significant bit first. The change appears three system clock edges after dclk_in rises, through a two-stage synchroniser and an edge detector. After bit 7 the read position wraps to bit 0.
- R7: A frame whose stop bit samples low is discarded. It gives no dr_n pulse, and the buffered byte and read position are kept.
- R8: A newly received byte overwrites the buffer even if the old byte was only partly read, and resets the read position to bit 0.
- R9: When mode_sel=1 and the block is not powered down, dclk_oe=0 and dclk_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sampling enable, sixteen per bit |
| rx_bit | input | 1 | Demodulated bit level |
| mode_sel | input | 1 | 0: raw stream with strobe; 1: buffered byte |
| ctl_a | input | 1 | Control input; both low with mode_sel=1 means power-down |
| ctl_b | input | 1 | Control input; both low with mode_sel=1 means power-down |
| dclk_in | input | 1 | External shift clock (used when mode_sel=1) |
| data_out | output | 1 | Data line |
| dclk_out | output | 1 | Bit-centre strobe (used when mode_sel=0) |
| dclk_oe | output | 1 | Output enable for the clock pad |
| dr_n | output | 1 | Data ready, active low |

## Verification
Two well-formed frames with different bit patterns check where the strobes fall and the least-significant-first order. A short low glitch must produce no strobe at all, which separates true start-bit confirmation from simple edge detection. In mode 1, frames with a good stop bit and a bad stop bit are compared: the bad one must leave both the buffer and the read position alone. Ten shift pulses show the read position wrapping. A byte that arrives halfway through a read shows the buffer being overwritten, and a frame sent during power-down must leave no trace once the block is powered up again.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_t;
endpackage

// File: rtl/fsk_framer.sv
module fsk_framer
    import fsk_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             tick,
    input  logic             rx_bit,
    output logic             strobe,
    output logic             byte_ok,
    output logic [NBITS-1:0] byte_q
);
    localparam int PW = $clog2(OSR);
    localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [PW-1:0] MID  = PW'(OSR / 2 - 1);
    localparam logic [PW-1:0] LAST = PW'(OSR - 1);

    fr_state_t        st, st_nx;
    logic [PW-1:0]    ph;
    logic [CW-1:0]    cnt;
    logic             prev;
    logic [NBITS-1:0] sh;
    logic             mid, last;

    assign mid  = tick && (ph == MID);
    assign last = tick && (ph == LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            FR_IDLE:  if (tick && prev && !rx_bit) st_nx = FR_START;
            FR_START: if (mid && rx_bit) st_nx = FR_IDLE;
                      else if (last) st_nx = FR_DATA;
            FR_DATA:  if (last && cnt == CW'(NBITS - 1)) st_nx = FR_STOP;
            FR_STOP:  if (mid) st_nx = FR_IDLE;
            default:  st_nx = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st <= FR_IDLE;
        else if (halt)  st <= FR_IDLE;
        else            st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            cnt  <= '0;
            prev <= 1'b1;
            sh   <= '0;
        end else if (halt) begin
            ph   <= '0;
            cnt  <= '0;
            prev <= 1'b1;
        end else if (tick) begin
            prev <= rx_bit;
            ph   <= (st == FR_IDLE) ? '0 : ph + 1'b1;
            if (st == FR_START) cnt <= '0;
            if (st == FR_DATA && mid) sh <= {rx_bit, sh[NBITS-1:1]};
            if (st == FR_DATA && last) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe  <= 1'b0;
            byte_ok <= 1'b0;
            byte_q  <= '0;
        end else if (halt) begin
            strobe  <= 1'b0;
            byte_ok <= 1'b0;
        end else begin
            strobe  <= mid && (st != FR_IDLE) && !(st == FR_START && rx_bit);
            byte_ok <= mid && (st == FR_STOP) && rx_bit;
            if (mid && st == FR_STOP && rx_bit) byte_q <= sh;
        end
    end

    // R7
    byte_ok_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok |-> strobe);

    // R1
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (st == FR_IDLE) && !strobe && !byte_ok);
endmodule

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     s <= '0;
        else if (halt)  s <= '0;
        else            s <= {s[STAGES-1:0], din};
    end

    assign rise = s[STAGES-1] && !s[STAGES];

    // R6
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(din, STAGES));
endmodule

// File: rtl/fsk_rdbuf.sv
module fsk_rdbuf #(
    parameter int OSR   = 16,
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             tick,
    input  logic             load,
    input  logic [NBITS-1:0] load_byte,
    input  logic             shift,
    output logic             bit_out,
    output logic             dr_n
);
    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int DW = $clog2(OSR + 1);

    logic [NBITS-1:0] hold;
    logic [IW-1:0]    idx;
    logic [DW-1:0]    drc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            idx  <= '0;
            drc  <= '0;
        end else if (halt) begin
            drc  <= '0;
        end else if (load) begin
            hold <= load_byte;
            idx  <= '0;
            drc  <= DW'(OSR);
        end else begin
            if (shift) idx <= (idx == IW'(NBITS - 1)) ? '0 : idx + 1'b1;
            if (tick && drc != '0) drc <= drc - 1'b1;
        end
    end

    assign bit_out = hold[idx];
    assign dr_n    = (drc == '0);

    // R5
    load_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !halt) |=> !dr_n && (bit_out == $past(load_byte[0])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(bit_out));
endmodule

// File: rtl/fsk_rx_iface.sv
module fsk_rx_iface #(
    parameter int OSR   = 16,
    parameter int NBITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_bit,
    input  logic mode_sel,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic dclk_in,
    output logic data_out,
    output logic dclk_out,
    output logic dclk_oe,
    output logic dr_n
);
    logic             pd;
    logic             strobe, byte_ok, shift, buf_bit, buf_dr_n;
    logic [NBITS-1:0] byte_q;

    assign pd = mode_sel && !ctl_a && !ctl_b;

    fsk_framer #(.OSR(OSR), .NBITS(NBITS)) u_framer (
        .clk(clk), .rst_n(rst_n), .halt(pd), .tick(os_tick), .rx_bit(rx_bit),
        .strobe(strobe), .byte_ok(byte_ok), .byte_q(byte_q)
    );

    fsk_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .halt(pd), .din(dclk_in), .rise(shift)
    );

    fsk_rdbuf #(.OSR(OSR), .NBITS(NBITS)) u_rdbuf (
        .clk(clk), .rst_n(rst_n), .halt(pd), .tick(os_tick),
        .load(byte_ok), .load_byte(byte_q), .shift(shift),
        .bit_out(buf_bit), .dr_n(buf_dr_n)
    );

    always_comb begin
        if (pd) begin
            data_out = 1'b0;
            dclk_out = 1'b0;
            dclk_oe  = 1'b0;
            dr_n     = 1'b1;
        end else if (!mode_sel) begin
            data_out = rx_bit;
            dclk_out = strobe;
            dclk_oe  = 1'b1;
            dr_n     = 1'b1;
        end else begin
            data_out = buf_bit;
            dclk_out = 1'b0;
            dclk_oe  = 1'b0;
            dr_n     = buf_dr_n;
        end
    end

    // R1
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !ctl_a && !ctl_b) |-> dr_n && !dclk_oe && !dclk_out && !data_out);

    // R9
    mode1_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && (ctl_a || ctl_b)) |-> !dclk_oe && !dclk_out);

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && os_tick) |=> !strobe);
endmodule

// File: tb/fsk_rx_iface_test.sv
module fsk_rx_iface_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, os_tick, rx_bit, mode_sel, ctl_a, ctl_b, dclk_in;
    logic data_out, dclk_out, dclk_oe, dr_n;

    int total = 0;
    int bad = 0;
    int E = 0;
    bit finished = 0;
    string tag = "R3 reset";

    bit       strobe_at[int];
    bit       inc_at[int];
    logic [7:0] load_at[int];
    logic [7:0] bufm = 8'h00;
    int       idxm = 0;
    int       dr_start = -1000;

    fsk_rx_iface uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_bit(rx_bit),
        .mode_sel(mode_sel), .ctl_a(ctl_a), .ctl_b(ctl_b), .dclk_in(dclk_in),
        .data_out(data_out), .dclk_out(dclk_out), .dclk_oe(dclk_oe), .dr_n(dr_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string name, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at edge %0d: actual=%0b expected=%0b", tag, name, E, act, exp);
        end
    endtask

    task automatic compare();
        logic pd, e_data, e_dclk, e_oe, e_dr;
        pd = mode_sel && !ctl_a && !ctl_b;
        if (pd) begin
            e_data = 0; e_dclk = 0; e_oe = 0; e_dr = 1;
        end else if (!mode_sel) begin
            e_data = rx_bit; e_dclk = strobe_at.exists(E); e_oe = 1; e_dr = 1;
        end else begin
            e_data = bufm[idxm]; e_dclk = 0; e_oe = 0;
            e_dr = !(E >= dr_start && E < dr_start + 16);
        end
        chk("data_out", data_out, e_data);
        chk("dclk_out", dclk_out, e_dclk);
        chk("dclk_oe", dclk_oe, e_oe);
        chk("dr_n", dr_n, e_dr);
    endtask

    task automatic step(input logic rxv);
        rx_bit = rxv;
        @(posedge clk);
        E++;
        if (load_at.exists(E)) begin
            bufm = load_at[E];
            idxm = 0;
            dr_start = E;
        end else if (inc_at.exists(E)) begin
            idxm = (idxm + 1) % 8;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input bit live);
        int k;
        k = E + 1;
        if (live) begin
            for (int j = 0; j < 10; j++) strobe_at[k + 16 * j + 8] = 1;
            if (stop) load_at[k + 153] = b;
        end
        repeat (16) step(1'b0);
        for (int i = 0; i < 8; i++) repeat (16) step(b[i]);
        repeat (16) step(stop);
        repeat (24) step(1'b1);
    endtask

    task automatic pulse_dclk();
        inc_at[E + 3] = 1;
        dclk_in = 1'b1;
        repeat (4) step(1'b1);
        dclk_in = 1'b0;
        repeat (4) step(1'b1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 0; os_tick = 1; rx_bit = 1; mode_sel = 0;
        ctl_a = 1; ctl_b = 0; dclk_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("dr_n", dr_n, 1'b1);
        chk("dclk_out", dclk_out, 1'b0);
        chk("dclk_oe", dclk_oe, 1'b1);
        chk("data_out", data_out, 1'b1);
        rst_n = 1;
        repeat (5) step(1'b1);

        tag = "R2 R3 mode0 frames";
        send_frame(8'hA5, 1'b1, 1);
        send_frame(8'h3C, 1'b1, 1);

        tag = "R4 start glitch";
        repeat (4) step(1'b0);
        repeat (30) step(1'b1);

        tag = "R7 bad stop mode0";
        send_frame(8'h5A, 1'b0, 1);
        repeat (16) step(1'b1);

        tag = "R5 R9 mode1 load";
        mode_sel = 1;
        repeat (4) step(1'b1);
        send_frame(8'hC3, 1'b1, 1);

        tag = "R6 shift and wrap";
        for (int n = 0; n < 10; n++) pulse_dclk();

        tag = "R7 bad stop mode1";
        send_frame(8'h0F, 1'b0, 1);
        repeat (16) step(1'b1);

        tag = "R8 overwrite";
        for (int n = 0; n < 3; n++) pulse_dclk();
        send_frame(8'h96, 1'b1, 1);
        pulse_dclk();

        tag = "R1 power down";
        ctl_a = 0;
        repeat (4) step(1'b1);
        send_frame(8'h55, 1'b1, 0);
        ctl_a = 1;
        repeat (8) step(1'b1);
        for (int n = 0; n < 2; n++) pulse_dclk();

        summary();
    end
endmodule